// File: doc/BRIEF.md
# Dual-Byte Bidirectional Transceiver Core

This block is the logic core of a two-byte bidirectional bus transceiver. Each byte lane has a 9-bit A side and a 9-bit B side, an active-low enable input and a direction input. The block copies each side's input value, without inversion, to the output of the other side. It also drives two active-high pad enables per lane, one for the A outputs and one for the B outputs. The tri-state pads themselves are outside the block. Each pad is modelled by a data-out bus and its enable.

Each lane also has a power-up lockout. While the power-on reset input is high, a lockout flag in every lane is set. The set flag keeps both pad enables of the lane low, whatever level the enable pin has. After power-on reset falls, a lane stays disabled until its enable pin is seen going from high to low. The enable pin is sampled on a free-running clock. Once that falling edge has been seen, the enable pin gates the outputs directly. A later assertion of power-on reset, as on power-down, locks the lane again.

Top module: `dual_xcvr_core`

## Requirements
- R1: With a lane unlocked, `g_n` low and `dir` at 1 (A to B), `b_oe` of that lane is 1 and `a_oe` is 0.
- R2: With a lane unlocked, `g_n` low and `dir` at 0 (B to A), `a_oe` of that lane is 1 and `b_oe` is 0.
- R3: While `g_n` of a lane is 1, both `a_oe` and `b_oe` of that lane are 0, for either direction, in the same cycle.
- R4: While `por` is 1, every `a_oe` and `b_oe` bit is 0, whatever the levels on `g_n` and `dir`, and every lane becomes locked.
- R5: A locked lane keeps both enables at 0 until a rising clock edge at which its `g_n` is 0, its `g_n` was 1 at the previous rising edge, and `por` is 0. The enables follow `g_n` from the cycle after that edge. The cycle in which `g_n` falls still shows both enables at 0.
- R6: Once a lane is unlocked, raising `g_n` and lowering it again re-enables the outputs at once, with no further lockout delay.
- R7: The two lanes lock and unlock independently. A falling edge on one lane's `g_n` does not unlock the other lane.
- R8: After `por` is released, a falling edge on `g_n` that happened while `por` was high does not count. A lane whose `g_n` stays low stays disabled until `g_n` goes high and then low again.
- R9: While `rst` is 1, and after it is released, every lane is locked with both enables at 0, and a `g_n` that is already low does not count as a falling edge.
- R10: For every lane and at all times, `a_out` equals `b_in` and `b_out` equals `a_in`, bit for bit (non-inverting).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the enable edge detector |
| rst | input | 1 | Synchronous active-high reset; locks all lanes |
| por | input | 1 | Power-on reset level, active high; forces outputs off and locks all lanes |
| g_n | input | 2 | Per-lane enable, active low (bit i = lane i) |
| dir | input | 2 | Per-lane direction: 1 = A to B, 0 = B to A |
| a_in | input | 18 | A-side pad inputs, 9 bits per lane, lane i at bits [9i+8:9i] |
| b_in | input | 18 | B-side pad inputs, same layout |
| a_out | output | 18 | A-side pad output data, same layout |
| a_oe | output | 2 | Per-lane A-side pad enable, active high |
| b_out | output | 18 | B-side pad output data, same layout |
| b_oe | output | 2 | Per-lane B-side pad enable, active high |

## Verification
The assertions check on every cycle that the A and B enables of a lane are never both high, and that a high enable pin or a high power-on reset forces both enables low. They also check that power-on reset always leaves the lockout set, and that the lockout only clears after a clock edge that saw the enable pin low with power-on reset low. Some behaviour only the bench scenarios can show. These are the one-cycle lockout delay after the first falling edge, the fact that an edge during power-on reset or an enable that is already low does not count, the independence of the two lanes, and the data values on both sides for several patterns.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned LANE_BITS = 9;
    localparam int unsigned LANE_COUNT = 2;

    typedef enum logic {
        DIR_B_TO_A = 1'b0,
        DIR_A_TO_B = 1'b1
    } flow_dir_e;

    typedef struct packed {
        logic a_en;
        logic b_en;
    } pad_en_t;

    // Falling edge of an active-low pin, seen between two samples.
    function automatic logic saw_fall(input logic prev_lvl, input logic cur_lvl);
        return prev_lvl & ~cur_lvl;
    endfunction

    // Split a lane's enable into the two pad enables by direction.
    function automatic pad_en_t steer(input logic live, input flow_dir_e d);
        pad_en_t r;
        r.a_en = live & (d == DIR_B_TO_A);
        r.b_en = live & (d == DIR_A_TO_B);
        return r;
    endfunction

endpackage

// File: rtl/xcvr_lockout.sv
module xcvr_lockout (
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic g_n,
    output logic locked
);
    import xcvr_pkg::*;

    logic g_prev_q;
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            g_prev_q <= 1'b0;
            lock_q   <= 1'b1;
        end else begin
            g_prev_q <= g_n;
            if (por) begin
                lock_q <= 1'b1;
            end else if (saw_fall(g_prev_q, g_n)) begin
                lock_q <= 1'b0;
            end
        end
    end

    assign locked = lock_q;

    // R4: a cycle with power-on reset leaves the lane locked
    assert_por_sets_lock_R4: assert property (@(posedge clk) disable iff (rst)
        $past(por) |-> locked);

    // R5: unlocking only follows a cycle with enable low and no power-on reset
    assert_unlock_needs_low_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> (!$past(g_n) && !$past(por)));

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int unsigned W = xcvr_pkg::LANE_BITS
) (
    input  logic         live,
    input  logic         dir,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         a_oe,
    output logic         b_oe
);
    import xcvr_pkg::*;

    pad_en_t en;

    always_comb begin
        en    = steer(live, flow_dir_e'(dir));
        a_oe  = en.a_en;
        b_oe  = en.b_en;
        a_out = b_in;
        b_out = a_in;
    end

endmodule

// File: rtl/dual_xcvr_core.sv
module dual_xcvr_core #(
    parameter int unsigned NLANE = xcvr_pkg::LANE_COUNT,
    parameter int unsigned W     = xcvr_pkg::LANE_BITS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   por,
    input  logic [NLANE-1:0]       g_n,
    input  logic [NLANE-1:0]       dir,
    input  logic [NLANE*W-1:0]     a_in,
    input  logic [NLANE*W-1:0]     b_in,
    output logic [NLANE*W-1:0]     a_out,
    output logic [NLANE-1:0]       a_oe,
    output logic [NLANE*W-1:0]     b_out,
    output logic [NLANE-1:0]       b_oe
);

    logic [NLANE-1:0] locked;
    logic [NLANE-1:0] live;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        xcvr_lockout u_lock (
            .clk    (clk),
            .rst    (rst),
            .por    (por),
            .g_n    (g_n[i]),
            .locked (locked[i])
        );

        assign live[i] = ~g_n[i] & ~locked[i] & ~por;

        xcvr_lane #(.W(W)) u_lane (
            .live  (live[i]),
            .dir   (dir[i]),
            .a_in  (a_in[i*W +: W]),
            .b_in  (b_in[i*W +: W]),
            .a_out (a_out[i*W +: W]),
            .b_out (b_out[i*W +: W]),
            .a_oe  (a_oe[i]),
            .b_oe  (b_oe[i])
        );

        // R3: enable pin high turns the lane off
        assert_pin_off_R3: assert property (@(posedge clk) disable iff (rst)
            g_n[i] |-> (!a_oe[i] && !b_oe[i]));

        // R1 / R2: at most one side of a lane drives
        assert_one_side_R1: assert property (@(posedge clk) disable iff (rst)
            !(a_oe[i] && b_oe[i]));
    end

    // R4: power-on reset forces every pad off
    assert_por_off_R4: assert property (@(posedge clk) disable iff (rst)
        por |-> (a_oe == '0 && b_oe == '0));

endmodule

// File: tb/tb_dual_xcvr_core.sv
module tb_dual_xcvr_core;

    localparam int W = 9;

    typedef struct {
        logic [1:0]      aoe;
        logic [1:0]      boe;
        logic [2*W-1:0]  ao;
        logic [2*W-1:0]  bo;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            por = 1'b0;
    logic [1:0]      g_n = 2'b00;
    logic [1:0]      dir = 2'b01;
    logic [2*W-1:0]  a_in = '0;
    logic [2*W-1:0]  b_in = '0;
    logic [2*W-1:0]  a_out;
    logic [2*W-1:0]  b_out;
    logic [1:0]      a_oe;
    logic [1:0]      b_oe;

    int checks = 0;
    int failures = 0;
    exp_t q[$];
    event chk_ev;

    always #4 clk = ~clk;

    dual_xcvr_core dut (
        .clk(clk), .rst(rst), .por(por), .g_n(g_n), .dir(dir),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
        .b_out(b_out), .b_oe(b_oe)
    );

    // Driver: apply inputs after a falling clock edge, then queue the expectation.
    task automatic step(input logic p, input logic [1:0] g, input logic [1:0] d,
                        input logic [2*W-1:0] ai, input logic [2*W-1:0] bi,
                        input logic [1:0] eaoe, input logic [1:0] eboe,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst  = 1'b0;
        por  = p;
        g_n  = g;
        dir  = d;
        a_in = ai;
        b_in = bi;
        #2;
        e.aoe = eaoe;
        e.boe = eboe;
        e.ao  = bi;   // R10: A outputs carry B inputs
        e.bo  = ai;   // R10: B outputs carry A inputs
        e.tag = tag;
        q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    // Monitor: pop and compare against the live outputs.
    initial begin
        exp_t e;
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (a_oe !== e.aoe || b_oe !== e.boe) begin
                    failures++;
                    $display("FAIL %s enables: a_oe=%b b_oe=%b expected a_oe=%b b_oe=%b",
                             e.tag, a_oe, b_oe, e.aoe, e.boe);
                end
                checks++;
                if (a_out !== e.ao || b_out !== e.bo) begin
                    failures++;
                    $display("FAIL R10 (%s) data: a_out=%h b_out=%h expected a_out=%h b_out=%h",
                             e.tag, a_out, b_out, e.ao, e.bo);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog expired: done=0 expected done=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R9: reset released with g_n already low: still locked
        step(0, 2'b00, 2'b01, 18'h1A5A5, 18'h05A5A, 2'b00, 2'b00, "R9 locked after reset");
        // R3: pins high
        step(0, 2'b11, 2'b01, 18'h00001, 18'h3FFFE, 2'b00, 2'b00, "R3 pins high");
        // R5: lane 0 falls, same cycle still off
        step(0, 2'b10, 2'b01, 18'h2AAAA, 18'h15555, 2'b00, 2'b00, "R5 falling cycle off");
        // R1: lane 0 unlocked, A to B
        step(0, 2'b10, 2'b01, 18'h3FFFF, 18'h00000, 2'b00, 2'b01, "R1 A to B");
        // R2: lane 0 B to A
        step(0, 2'b10, 2'b00, 18'h12345, 18'h2ABCD, 2'b01, 2'b00, "R2 B to A");
        // R3: lane 0 pin high while unlocked
        step(0, 2'b11, 2'b00, 18'h0F0F0, 18'h30F0F, 2'b00, 2'b00, "R3 unlocked pin high");
        // R6: low again re-enables at once
        step(0, 2'b10, 2'b00, 18'h00100, 18'h00200, 2'b01, 2'b00, "R6 immediate re-enable");
        // R7: lane 1 falls: lane 1 still locked, lane 0 unaffected
        step(0, 2'b00, 2'b00, 18'h1C71C, 18'h238E3, 2'b01, 2'b00, "R7 lane1 still locked");
        // R7: lane 1 unlocked in the next cycle
        step(0, 2'b00, 2'b00, 18'h00000, 18'h3FFFF, 2'b11, 2'b00, "R7 lane1 unlocked");
        // R4: power-on reset forces everything off
        step(1, 2'b00, 2'b00, 18'h11111, 18'h22222, 2'b00, 2'b00, "R4 por off");
        step(1, 2'b11, 2'b11, 18'h33333, 18'h04444, 2'b00, 2'b00, "R4 por pins high");
        step(1, 2'b00, 2'b00, 18'h05555, 18'h06666, 2'b00, 2'b00, "R4 por edge ignored");
        // R8: release with pins low: still locked
        step(0, 2'b00, 2'b00, 18'h07777, 18'h08888, 2'b00, 2'b00, "R8 released locked");
        step(0, 2'b00, 2'b00, 18'h09999, 18'h0AAAA, 2'b00, 2'b00, "R8 still locked");
        step(0, 2'b11, 2'b00, 18'h0BBBB, 18'h0CCCC, 2'b00, 2'b00, "R8 pins high");
        step(0, 2'b00, 2'b00, 18'h0DDDD, 18'h0EEEE, 2'b00, 2'b00, "R8 fall cycle off");
        step(0, 2'b00, 2'b00, 18'h0FFFF, 18'h10000, 2'b11, 2'b00, "R8 unlocked B to A");
        // R1: both lanes A to B
        step(0, 2'b00, 2'b11, 18'h2DEAD, 18'h1BEEF, 2'b00, 2'b11, "R1 both A to B");
        // R9: reset again relocks
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        step(0, 2'b00, 2'b11, 18'h00F00, 18'h0F000, 2'b00, 2'b00, "R9 relocked by reset");
        #10;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule